// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block walks a key matrix of up to eight rows by eight columns. It pulls one row low at a time and reads the column lines back through a synchronizer. It keeps a debounced picture of the matrix and reports each debounced change as a packed byte. Software picks which rows are driven and which columns are read through two mask inputs. It sets the quiet time a change must hold before it counts, and starts or stops the scan with an enable. A free-running `tick` input sets the length of each row slot.

Three report bytes hold the matrix keys that are currently or were recently reported. Each byte keeps an up/down flag, the row number and the column number. Having three bytes lets software see three keys down at once, which is what it needs to spot a possible ghost key. A separate nibble gives the state of up to four dedicated keys. A one-cycle `key_evt` pulse marks every update of a report byte.

Top module: `kpd_matrix_scan`

## Requirements
- R1: While reset is held and just after it, every report byte reads 0xF8 (up flag set, row field 4'b1111 = no key, column 0), `ded_stat` reads all ones, `row_drv_n` is all ones and `key_evt` is low.
- R2: At most one row line is low at any time, and the column lines are sampled at the `tick` that ends the slot of the row being driven.
- R3: With `scan_en` low, no row is driven and no new key change is reported. Raising `scan_en` again resumes scanning.
- R4: A key in a column whose `col_en` bit is 0 is read as released and is never reported.
- R5: The debounced state of a key follows its sampled state only after no sampled change has occurred anywhere in the matrix for `db_time` tick periods. A change that reverts within that time is never reported.
- R6: A newly pressed key is written into the lowest-numbered free report byte as {bit 7 = 0 (down), bits [6:3] = row, bits [2:0] = column}. Slot k sits in `key_rpt[8k+7:8k]`.
- R7: When a reported key is released, its byte keeps the row and column, bit 7 becomes 1 (up), and the slot becomes free.
- R8: When all slots are occupied, a further pressed key is ignored on press and on release. Keys already reported keep their slots.
- R9: Several keys that settle together are handled one per clock in ascending key index (row*COLS + column). A lower index therefore wins the last free slot.
- R10: `key_evt` is high for exactly one clock for each report byte update, and never otherwise.
- R11: `ded_stat` equals `ded_key_n` after a two-flop synchronizer (0 = down, 1 = up).
- R12: A row whose `row_en` bit is 0 is never driven, and its keys are never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse ending each row slot |
| scan_en | input | 1 | 1 = scan, 0 = stop |
| row_en | input | ROWS | Per-row scan enable |
| col_en | input | COLS | Per-column read enable |
| db_time | input | DBW | Quiet time in tick periods |
| row_drv_n | output | ROWS | Row drive, active low |
| col_sense_n | input | COLS | Column sense, low = key closed on the driven row |
| ded_key_n | input | DED | Raw dedicated keys, low = down |
| key_rpt | output | SLOTS*8 | Report bytes, slot k at bits [8k+7:8k] |
| ded_stat | output | DED | Synchronized dedicated key status |
| key_evt | output | 1 | Pulses once per report update |

## Verification
The main function is driven by a sequence of held-key sets. Keys are added one at a time, so that the choice of the lowest free slot can be seen. A fourth key is pressed with every slot occupied, which separates ignoring it from evicting an older key. Releases of reported and unreported keys show that only owned slots flip their up flag. Two keys that settle in the same frame show whether commits run in index order. Directed cases then cover a change shorter than the quiet time against one longer, a masked column and a masked row against their unmasked neighbours, and a stopped scan against a resumed one.

// File: rtl/kpd_scan_pkg.sv
package kpd_scan_pkg;

  typedef struct packed {
    logic       up;
    logic [3:0] row;
    logic [2:0] col;
  } key_rpt_t;

  localparam key_rpt_t RPT_EMPTY = '{up: 1'b1, row: 4'hF, col: 3'd0};

  // next enabled row after cur, wrapping; cur itself if it is the only one
  function automatic logic [2:0] next_row(input logic [7:0] en, input logic [2:0] cur);
    logic [2:0] nxt;
    nxt = cur;
    for (int i = 7; i >= 1; i--) begin
      if (en[cur + 3'(i)]) nxt = cur + 3'(i);
    end
    return nxt;
  endfunction

  function automatic logic [3:0] key_row(input int unsigned idx, input int unsigned cols);
    return 4'(idx / cols);
  endfunction

  function automatic logic [2:0] key_col(input int unsigned idx, input int unsigned cols);
    return 3'(idx % cols);
  endfunction

  function automatic key_rpt_t make_rpt(input logic up, input logic [3:0] row,
                                        input logic [2:0] col);
    key_rpt_t r;
    r.up  = up;
    r.row = row;
    r.col = col;
    return r;
  endfunction

endpackage

// File: rtl/kpd_row_seq.sv
module kpd_row_seq
  import kpd_scan_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            scan_en,
  input  logic [ROWS-1:0] row_en,
  input  logic [COLS-1:0] col_en,
  input  logic [COLS-1:0] col_sense_n,
  output logic [ROWS-1:0] row_drv_n,
  output logic            samp_vld,
  output logic [2:0]      samp_row,
  output logic [COLS-1:0] samp_cols
);

  logic [7:0]      en8;
  logic            running;
  logic [2:0]      cur_row;
  logic [COLS-1:0] col_s1, col_s2;

  assign en8 = 8'(row_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_s1 <= '1;
      col_s2 <= '1;
    end else begin
      col_s1 <= col_sense_n;
      col_s2 <= col_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      cur_row   <= '0;
      samp_vld  <= 1'b0;
      samp_row  <= '0;
      samp_cols <= '0;
    end else begin
      samp_vld <= 1'b0;
      if (!scan_en) begin
        running <= 1'b0;
      end else if (!running) begin
        running <= 1'b1;
        cur_row <= next_row(en8, 3'd7);
      end else if (tick) begin
        samp_vld  <= en8[cur_row];
        samp_row  <= cur_row;
        samp_cols <= ~col_s2 & col_en;
        cur_row   <= next_row(en8, cur_row);
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_drv
    assign row_drv_n[r] = !(running && en8[r] && (cur_row == 3'(r)));
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (&row_drv_n)); // R3
  AST_SAMPLED_ROW_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    samp_vld |-> ((($past(row_drv_n) >> samp_row) & ROWS'(1)) == '0)); // R2

endmodule

// File: rtl/kpd_debounce.sv
module kpd_debounce
  import kpd_scan_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DBW  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            samp_vld,
  input  logic [2:0]      samp_row,
  input  logic [COLS-1:0] samp_cols,
  input  logic [DBW-1:0]  db_time,
  output logic            chg_vld,
  output logic            chg_down,
  output logic [3:0]      chg_row,
  output logic [2:0]      chg_col
);

  localparam int KEYS = ROWS * COLS;
  localparam int KW   = (KEYS > 1) ? $clog2(KEYS) : 1;
  localparam logic [DBW-1:0] CNT_MAX = '1;

  logic [KEYS-1:0] raw_q, deb_q, diff;
  logic [DBW-1:0]  stab_cnt;
  logic            row_changed;
  logic            quiet;
  logic [KW-1:0]   sel_idx;

  always_comb begin
    row_changed = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      if (samp_vld && samp_row == 3'(r) && raw_q[r*COLS +: COLS] != samp_cols)
        row_changed = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q    <= '0;
      stab_cnt <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (samp_vld && samp_row == 3'(r)) raw_q[r*COLS +: COLS] <= samp_cols;
      end
      if (row_changed)                        stab_cnt <= '0;
      else if (tick && stab_cnt != CNT_MAX)   stab_cnt <= stab_cnt + 1'b1;
    end
  end

  assign diff  = raw_q ^ deb_q;
  assign quiet = (stab_cnt >= db_time);

  always_comb begin
    sel_idx = '0;
    for (int i = KEYS - 1; i >= 0; i--) begin
      if (diff[i]) sel_idx = KW'(i);
    end
  end

  assign chg_vld  = quiet && (|diff);
  assign chg_down = raw_q[sel_idx];
  assign chg_row  = key_row(32'(sel_idx), COLS);
  assign chg_col  = key_col(32'(sel_idx), COLS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       deb_q <= '0;
    else if (chg_vld) deb_q[sel_idx] <= raw_q[sel_idx];
  end

  AST_DEB_TOWARD_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (deb_q != $past(deb_q)) |-> (((deb_q ^ $past(deb_q)) & (deb_q ^ $past(raw_q))) == '0)); // R5
  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(deb_q ^ $past(deb_q)) <= 1); // R9

endmodule

// File: rtl/kpd_slots.sv
module kpd_slots
  import kpd_scan_pkg::*;
#(
  parameter int SLOTS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chg_vld,
  input  logic               chg_down,
  input  logic [3:0]         chg_row,
  input  logic [2:0]         chg_col,
  output logic [SLOTS*8-1:0] rpt_bytes,
  output logic               evt
);

  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  key_rpt_t         rpt_q [SLOTS];
  logic [SLOTS-1:0] occ_q, hit, free;
  logic [SW-1:0]    free_idx, hit_idx;

  always_comb begin
    free_idx = '0;
    hit_idx  = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      hit[s]  = occ_q[s] && rpt_q[s].row == chg_row && rpt_q[s].col == chg_col;
      free[s] = !occ_q[s];
      if (free[s]) free_idx = SW'(s);
      if (hit[s])  hit_idx  = SW'(s);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      evt   <= 1'b0;
      for (int s = 0; s < SLOTS; s++) rpt_q[s] <= RPT_EMPTY;
    end else begin
      evt <= 1'b0;
      if (chg_vld) begin
        if (chg_down) begin
          if (|free) begin
            rpt_q[free_idx] <= make_rpt(1'b0, chg_row, chg_col);
            occ_q[free_idx] <= 1'b1;
            evt             <= 1'b1;
          end
        end else if (|hit) begin
          rpt_q[hit_idx].up <= 1'b1;
          occ_q[hit_idx]    <= 1'b0;
          evt               <= 1'b1;
        end
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_out
    assign rpt_bytes[s*8 +: 8] = rpt_q[s];
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_uniq_i
    for (genvar j = i + 1; j < SLOTS; j++) begin : g_uniq_j
      AST_SLOT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        !(occ_q[i] && occ_q[j] && rpt_q[i][6:0] == rpt_q[j][6:0])); // R8
    end
  end

  AST_EVT_MEANS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (rpt_bytes != $past(rpt_bytes))); // R10
  AST_UPDATE_MEANS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_bytes != $past(rpt_bytes)) |-> evt); // R10

endmodule

// File: rtl/kpd_matrix_scan.sv
module kpd_matrix_scan
  import kpd_scan_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int SLOTS = 3,
  parameter int DBW   = 7,
  parameter int DED   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               scan_en,
  input  logic [ROWS-1:0]    row_en,
  input  logic [COLS-1:0]    col_en,
  input  logic [DBW-1:0]     db_time,
  output logic [ROWS-1:0]    row_drv_n,
  input  logic [COLS-1:0]    col_sense_n,
  input  logic [DED-1:0]     ded_key_n,
  output logic [SLOTS*8-1:0] key_rpt,
  output logic [DED-1:0]     ded_stat,
  output logic               key_evt
);

  logic            samp_vld;
  logic [2:0]      samp_row;
  logic [COLS-1:0] samp_cols;
  logic            chg_vld, chg_down;
  logic [3:0]      chg_row;
  logic [2:0]      chg_col;
  logic [DED-1:0]  ded_s1;

  kpd_row_seq #(.ROWS(ROWS), .COLS(COLS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .scan_en(scan_en),
    .row_en(row_en), .col_en(col_en), .col_sense_n(col_sense_n),
    .row_drv_n(row_drv_n), .samp_vld(samp_vld), .samp_row(samp_row),
    .samp_cols(samp_cols)
  );

  kpd_debounce #(.ROWS(ROWS), .COLS(COLS), .DBW(DBW)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .samp_vld(samp_vld),
    .samp_row(samp_row), .samp_cols(samp_cols), .db_time(db_time),
    .chg_vld(chg_vld), .chg_down(chg_down), .chg_row(chg_row), .chg_col(chg_col)
  );

  kpd_slots #(.SLOTS(SLOTS)) u_slots (
    .clk(clk), .rst_n(rst_n), .chg_vld(chg_vld), .chg_down(chg_down),
    .chg_row(chg_row), .chg_col(chg_col), .rpt_bytes(key_rpt), .evt(key_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ded_s1   <= '1;
      ded_stat <= '1;
    end else begin
      ded_s1   <= ded_key_n;
      ded_stat <= ded_s1;
    end
  end

  AST_DED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ded_s1 == $past(ded_key_n)); // R11

endmodule

// File: tb/kpd_matrix_scan_bench.sv
module kpd_matrix_scan_bench;

  logic        clk = 1'b0;
  logic        rst_n, tick, scan_en;
  logic [7:0]  row_en, col_en;
  logic [6:0]  db_time;
  logic [7:0]  row_drv_n, col_sense_n;
  logic [3:0]  ded_key_n, ded_stat;
  logic [23:0] key_rpt;
  logic        key_evt;
  logic [63:0] held;

  int checks = 0, errors = 0, evt_cnt = 0, row_viol = 0;

  always #2.5 clk = ~clk;

  kpd_matrix_scan u_kpd_matrix_scan (
    .clk(clk), .rst_n(rst_n), .tick(tick), .scan_en(scan_en), .row_en(row_en),
    .col_en(col_en), .db_time(db_time), .row_drv_n(row_drv_n),
    .col_sense_n(col_sense_n), .ded_key_n(ded_key_n), .key_rpt(key_rpt),
    .ded_stat(ded_stat), .key_evt(key_evt)
  );

  // keyboard with a diode per key: a closed key pulls its column on the driven row
  always_comb begin
    for (int c = 0; c < 8; c++) begin
      col_sense_n[c] = 1'b1;
      for (int r = 0; r < 8; r++)
        if (held[r*8+c] && !row_drv_n[r]) col_sense_n[c] = 1'b0;
    end
  end

  initial begin
    tick = 1'b0;
    forever begin
      repeat (7) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (key_evt) evt_cnt++;
      if ($countones(~row_drv_n) > 1 || ((~row_drv_n & ~row_en) != 8'h00)) row_viol++;
    end
  end

  function automatic logic [63:0] kb(input int r, input int c);
    return 64'd1 << (r * 8 + c);
  endfunction

  typedef struct packed {
    logic [63:0] keys;
    logic [7:0]  e0, e1, e2;
    logic [3:0]  nevt;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{kb(2,5),                                 8'h15, 8'hF8, 8'hF8, 4'd1},
    '{kb(2,5)|kb(7,0),                         8'h15, 8'h38, 8'hF8, 4'd1},
    '{kb(2,5)|kb(7,0)|kb(0,7),                 8'h15, 8'h38, 8'h07, 4'd1},
    '{kb(2,5)|kb(7,0)|kb(0,7)|kb(4,4),         8'h15, 8'h38, 8'h07, 4'd0},
    '{kb(7,0)|kb(0,7)|kb(4,4),                 8'h95, 8'h38, 8'h07, 4'd1},
    '{kb(0,7),                                 8'h95, 8'hB8, 8'h07, 4'd1},
    '{kb(0,7)|kb(3,1),                         8'h19, 8'hB8, 8'h07, 4'd1},
    '{kb(0,7)|kb(3,1)|kb(1,1)|kb(6,6),         8'h19, 8'h09, 8'h07, 4'd1},
    '{64'd0,                                   8'h99, 8'h89, 8'h87, 4'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * 8) @(negedge clk);
  endtask

  task automatic do_reset(input logic [7:0] re, input logic [7:0] ce, input logic [6:0] db);
    rst_n = 1'b0;
    held = '0;
    row_en = re;
    col_en = ce;
    db_time = db;
    scan_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    evt_cnt = 0;
    @(negedge clk);
  endtask

  initial begin
    int ev0;
    rst_n = 1'b0; held = '0; scan_en = 1'b1; row_en = 8'hFF; col_en = 8'hFF;
    db_time = 7'd3; ded_key_n = 4'hF;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rpt", {8'h0, key_rpt}, 32'h00F8F8F8);
    check("R1 drv", {24'h0, row_drv_n}, 32'hFF);
    check("R1 ded", {28'h0, ded_stat}, 32'hF);
    check("R1 evt", {31'h0, key_evt}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 R7 R8 R9 R10: held-key sequence
    for (int i = 0; i < 9; i++) begin
      ev0 = evt_cnt;
      held = VEC[i].keys;
      wait_ticks(16);
      check($sformatf("R6/R7 step %0d slot0", i), {24'h0, key_rpt[7:0]},   {24'h0, VEC[i].e0});
      check($sformatf("R8/R9 step %0d slot1", i), {24'h0, key_rpt[15:8]},  {24'h0, VEC[i].e1});
      check($sformatf("R8 step %0d slot2", i),    {24'h0, key_rpt[23:16]}, {24'h0, VEC[i].e2});
      check($sformatf("R10 step %0d events", i),  32'(evt_cnt - ev0), {28'h0, VEC[i].nevt});
    end

    // R5: quiet time of 20 ticks
    do_reset(8'hFF, 8'hFF, 7'd20);
    held = kb(5,2);
    wait_ticks(13);
    check("R5 early", {24'h0, key_rpt[7:0]}, 32'hF8);
    wait_ticks(20);
    check("R5 settled", {24'h0, key_rpt[7:0]}, 32'h2A);
    ev0 = evt_cnt;
    held = '0;
    wait_ticks(10);
    held = kb(5,2);
    wait_ticks(35);
    check("R5 glitch ignored", {24'h0, key_rpt[7:0]}, 32'h2A);
    check("R5 glitch no event", 32'(evt_cnt - ev0), 32'd0);

    // R4: column 5 masked
    do_reset(8'hFF, 8'hDF, 7'd3);
    held = kb(2,5);
    wait_ticks(16);
    check("R4 masked col", {24'h0, key_rpt[7:0]}, 32'hF8);
    check("R4 no event", 32'(evt_cnt), 32'd0);
    held = kb(2,5) | kb(2,4);
    wait_ticks(16);
    check("R4 open col", {24'h0, key_rpt[7:0]}, 32'h14);

    // R12: row 3 masked
    do_reset(8'hF7, 8'hFF, 7'd3);
    held = kb(3,1);
    wait_ticks(16);
    check("R12 masked row", {24'h0, key_rpt[7:0]}, 32'hF8);
    held = kb(3,1) | kb(4,6);
    wait_ticks(16);
    check("R12 open row", {24'h0, key_rpt[7:0]}, 32'h26);

    // R3: stopped scan
    do_reset(8'hFF, 8'hFF, 7'd3);
    scan_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 idle drive", {24'h0, row_drv_n}, 32'hFF);
    held = kb(1,2);
    wait_ticks(16);
    check("R3 no report", {24'h0, key_rpt[7:0]}, 32'hF8);
    check("R3 no event", 32'(evt_cnt), 32'd0);
    scan_en = 1'b1;
    wait_ticks(16);
    check("R3 resumed", {24'h0, key_rpt[7:0]}, 32'h0A);

    // R11: dedicated keys
    ded_key_n = 4'b1010;
    @(negedge clk);
    check("R11 not yet", {28'h0, ded_stat}, 32'hF);
    repeat (2) @(negedge clk);
    check("R11 status", {28'h0, ded_stat}, 32'hA);

    // R2: single active row, only enabled rows, over the whole run
    check("R2 row drive", 32'(row_viol), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule